// File: doc/BRIEF.md
# Near-Field Receive Frame Decoder

This block turns the oversampled, demodulated line signal of a near-field link into a serial stream of decoded bits. It finds the start of a frame, cuts the incoming samples into eight-sample bit windows and classifies each window by which of its two halves carries modulation. The result is a bit value, a collision, or the end of the frame. It uses Manchester rules or pause-position (Modified Miller) rules, and the choice depends on link rate, device role and active/passive mode.

The control unit starts a reception by pulsing `start`. The decoder then reports `sof_flag` and a strobe for every recovered bit on `dataout`, and ends with `eof_flag`. Bits are grouped into bytes of eight data bits followed by an odd parity bit. The block raises a sticky parity error and pulses `byte_done` at the end of each byte. A 7-bit short frame carries no parity bit, and `byte_done` comes with `eof_flag` instead. In Manchester coding, a window with modulation in both halves is a collision. The index of the first such bit is held for the anti-collision loop.

Top module: `nfc_frame_decoder`

## Requirements
- R1: After `start`, the first modulated sample (`signal_in`=1) opens a candidate start window of eight samples. A half of a window counts as modulated when at least 2 of its 4 samples are 1. A window with only the first half modulated gives a one-cycle `sof_flag`. Any other window is dropped, and the search for the next modulated sample begins again.
- R2: `rate` sets the sample spacing. 00 takes one sample every 4 clocks, 01 one every 2 clocks, and 10 or 11 one every clock.
- R3: Pause-position coding is used when `rate`=00 and either `role`=0 (target) or `mode`=1 (active). Manchester coding is used otherwise.
- R4: In Manchester coding, first half only gives 1, second half only gives 0, and both halves give 1 plus a collision.
- R5: In pause-position coding, a pause in the second half gives 1, and a pause only in the first half gives 0. A window with no pause gives 0 after a 1 and ends the frame after a 0 or after the start. The logic 0 just before that end is not output.
- R6: In Manchester coding, a window with no modulation in either half ends the frame.
- R7: Each decoded bit appears on `dataout` with a one-cycle `bit_strobe`, in received order. `eof_flag` pulses once per frame.
- R8: Bits are counted in groups of nine: eight data bits, then a parity bit. `par_err` is set when the parity bit equals the XOR of the eight data bits (odd parity). It stays set until the next `start`.
- R9: `byte_done` pulses with the strobe of each parity bit. In a frame of exactly 7 bits, it pulses together with `eof_flag`, and no parity check takes place.
- R10: `coll_flag` is set on the first collision, and `coll_idx` holds that bit's zero-based index in the frame. Later collisions in the same frame change neither.
- R11: After the end of a frame the decoder is idle and ignores `signal_in` until `start`. `start` clears `coll_flag`, `coll_idx` and `par_err`.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 passive, 1 active |
| rate | input | 2 | Link rate: 00, 01, 10/11 from slowest to fastest |
| role | input | 1 | 0 target, 1 initiator |
| start | input | 1 | Arms a reception, clears frame status |
| signal_in | input | 1 | Demodulated line sample, 1 = modulation |
| dataout | output | 1 | Decoded bit |
| bit_strobe | output | 1 | Pulse marking a valid `dataout` |
| sof_flag | output | 1 | Pulse on start of frame |
| eof_flag | output | 1 | Pulse on end of frame |
| coll_flag | output | 1 | Sticky collision flag |
| coll_idx | output | IDX_W | Index of first colliding bit |
| par_err | output | 1 | Sticky parity error |
| byte_done | output | 1 | Pulse at end of each byte or short frame |

## Verification
The bench targets pause-position frames whose last data bit is 1. A decoder that does not hold back and drop the closing logic 0 would output one extra 0 bit. That bit would also shift parity and byte counts. Two collisions are sent in one frame, and the reported index must be the first one. A design that overwrites the index would report the later bit. Short 7-bit frames must give `byte_done` with no parity error, and a single glitch sample or a window with both halves modulated must not be taken as a start. Correct and corrupted parity at all three rates, plus inputs sent while idle, catch wrong sample spacing and wrong status clearing.

// File: rtl/nfc_frame_decoder.sv
module nfc_frame_decoder #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic [1:0]       rate,
  input  logic             role,
  input  logic             start,
  input  logic             signal_in,
  output logic             dataout,
  output logic             bit_strobe,
  output logic             sof_flag,
  output logic             eof_flag,
  output logic             coll_flag,
  output logic [IDX_W-1:0] coll_idx,
  output logic             par_err,
  output logic             byte_done
);

  typedef enum logic [1:0] {S_IDLE, S_HUNT, S_DEC, S_EOF} st_t;
  st_t st;

  logic [1:0]       div;
  logic [2:0]       phase;
  logic [6:0]       sr;
  logic             prev, pend_v, pend_b;
  logic [IDX_W-1:0] bit_cnt;
  logic [3:0]       pos;
  logic             ones;

  function automatic logic half_on(input logic [3:0] h);
    logic [2:0] s;
    s = 3'(h[0]) + 3'(h[1]) + 3'(h[2]) + 3'(h[3]);
    return s >= 3'd2;
  endfunction

  wire shift_en = (rate == 2'b00) ? (div == 2'b00) :
                  (rate == 2'b01) ? !div[0] : 1'b1;
  wire miller   = (rate == 2'b00) && (!role || mode);
  wire [7:0] win = {sr, signal_in};
  wire win_done = shift_en && (phase == 3'd7);
  wire h1 = half_on(win[7:4]);
  wire h2 = half_on(win[3:0]);

  logic dec_bit, dec_end, dec_coll;
  always_comb begin
    dec_bit  = 1'b0;
    dec_end  = 1'b0;
    dec_coll = 1'b0;
    if (miller) begin
      if (h2)        dec_bit = 1'b1;
      else if (h1)   dec_bit = 1'b0;
      else if (prev) dec_bit = 1'b0;
      else           dec_end = 1'b1;
    end else begin
      dec_bit  = h1;
      dec_coll = h1 && h2;
      dec_end  = !h1 && !h2;
    end
  end

  wire emit = win_done && (st == S_DEC) && !dec_end && (!miller || pend_v);
  wire ebit = miller ? pend_b : dec_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; phase <= '0; sr <= '0;
      prev <= 1'b0; pend_v <= 1'b0; pend_b <= 1'b0;
      bit_cnt <= '0; pos <= '0; ones <= 1'b0;
      dataout <= 1'b0; bit_strobe <= 1'b0; sof_flag <= 1'b0; eof_flag <= 1'b0;
      coll_flag <= 1'b0; coll_idx <= '0; par_err <= 1'b0; byte_done <= 1'b0;
    end else begin
      div        <= div + 2'd1;
      sof_flag   <= 1'b0;
      eof_flag   <= 1'b0;
      bit_strobe <= 1'b0;
      byte_done  <= 1'b0;
      if (shift_en) sr <= win[6:0];
      case (st)
        S_IDLE: begin
          phase <= '0;
          if (start) begin
            st <= S_HUNT;
            coll_flag <= 1'b0; coll_idx <= '0; par_err <= 1'b0; dataout <= 1'b0;
          end
        end
        S_HUNT: begin
          if (shift_en && (phase != 3'd0 || signal_in)) phase <= phase + 3'd1;
          if (win_done && h1 && !h2) begin
            st <= S_DEC; sof_flag <= 1'b1;
            prev <= 1'b0; pend_v <= 1'b0; bit_cnt <= '0; pos <= '0; ones <= 1'b0;
          end
        end
        S_DEC: begin
          if (shift_en) phase <= phase + 3'd1;
          if (win_done) begin
            if (dec_end) begin
              st <= S_EOF; eof_flag <= 1'b1;
              if (bit_cnt == IDX_W'(7)) byte_done <= 1'b1;
            end else begin
              prev <= dec_bit; pend_v <= 1'b1; pend_b <= dec_bit;
              if (dec_coll && !coll_flag) begin
                coll_flag <= 1'b1; coll_idx <= bit_cnt;
              end
            end
          end
          if (emit) begin
            dataout <= ebit; bit_strobe <= 1'b1;
            if (bit_cnt != {IDX_W{1'b1}}) bit_cnt <= bit_cnt + 1'b1;
            if (pos == 4'd8) begin
              pos <= '0; ones <= 1'b0; byte_done <= 1'b1;
              if (ones == ebit) par_err <= 1'b1;
            end else begin
              pos <= pos + 4'd1; ones <= ones ^ ebit;
            end
          end
        end
        default: begin
          st <= S_IDLE; phase <= '0;
        end
      endcase
    end
  end

  assert_sof_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sof_flag |=> !sof_flag);
  assert_strobe_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);
  assert_eof_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eof_flag |=> (!eof_flag && !bit_strobe && !sof_flag));
  assert_bd_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (bit_strobe || eof_flag));
  assert_coll_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !(st == S_IDLE && start)) |=> (coll_flag && $stable(coll_idx)));
  assert_coll_manch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_flag) |-> !$past(miller));
  assert_par_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !(st == S_IDLE && start)) |=> par_err);

endmodule

// File: tb/tb_nfc_frame_decoder.sv
module tb_nfc_frame_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mode, role, start, signal_in;
  logic [1:0] rate;
  logic dataout, bit_strobe, sof_flag, eof_flag, coll_flag, par_err, byte_done;
  logic [7:0] coll_idx;

  nfc_frame_decoder dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate(rate), .role(role),
    .start(start), .signal_in(signal_in), .dataout(dataout),
    .bit_strobe(bit_strobe), .sof_flag(sof_flag), .eof_flag(eof_flag),
    .coll_flag(coll_flag), .coll_idx(coll_idx), .par_err(par_err),
    .byte_done(byte_done)
  );

  int vec = 0, bad = 0;
  logic tx [0:511];
  logic rx [0:511];
  int tx_n = 0, rx_n = 0, n_sof = 0, n_eof = 0, n_bd = 0;

  always @(negedge clk) if (rst_n) begin
    if (bit_strobe && rx_n < 512) begin rx[rx_n] = dataout; rx_n++; end
    if (sof_flag) n_sof++;
    if (eof_flag) n_eof++;
    if (byte_done) n_bd++;
  end

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_miller();
    return (rate == 2'b00) && (role == 1'b0 || mode == 1'b1);
  endfunction

  function automatic int nclk();
    return (rate == 2'b00) ? 4 : (rate == 2'b01) ? 2 : 1;
  endfunction

  function automatic int exp_perr();
    for (int b = 0; b + 9 <= tx_n; b += 9) begin
      logic x = 1'b0;
      for (int k = 0; k < 8; k++) x ^= tx[b + k];
      if (x == tx[b + 8]) return 1;
    end
    return 0;
  endfunction

  function automatic int exp_bd();
    return tx_n / 9 + ((tx_n == 7) ? 1 : 0);
  endfunction

  task automatic put_win(input logic [7:0] w);
    for (int i = 7; i >= 0; i--) begin
      signal_in = w[i];
      repeat (nclk()) @(negedge clk);
    end
  endtask

  task automatic build(input int nbytes, input int extra, input bit corrupt);
    tx_n = 0;
    for (int b = 0; b < nbytes; b++) begin
      logic x = 1'b0;
      for (int k = 0; k < 8; k++) begin
        tx[tx_n] = 1'($urandom); x ^= tx[tx_n]; tx_n++;
      end
      tx[tx_n] = ~x ^ ((corrupt && b == nbytes - 1) ? 1'b1 : 1'b0);
      tx_n++;
    end
    for (int k = 0; k < extra; k++) begin tx[tx_n] = 1'($urandom); tx_n++; end
  endtask

  task automatic send(input int c1, input int c2, input logic [7:0] pre);
    logic prv;
    bit mil = is_miller();
    if (pre != 8'h00) begin put_win(pre); put_win(8'h00); put_win(8'h00); end
    put_win(8'h00);
    put_win(mil ? 8'b11000000 : 8'b11110000);
    prv = 1'b0;
    for (int i = 0; i < tx_n; i++) begin
      if (mil) begin
        if (tx[i]) put_win(8'b00001100);
        else if (!prv) put_win(8'b11000000);
        else put_win(8'h00);
        prv = tx[i];
      end else if (i == c1 || i == c2) put_win(8'hFF);
      else put_win(tx[i] ? 8'hF0 : 8'h0F);
    end
    if (mil) put_win(prv ? 8'h00 : 8'b11000000);
    put_win(8'h00);
    put_win(8'h00);
    repeat (20) @(negedge clk);
  endtask

  task automatic run(input string tag, input int c1, input int c2, input logic [7:0] pre);
    int mism = 0;
    int ec = (c1 >= 0) ? c1 : c2;
    if (c1 >= 0) tx[c1] = 1'b1;
    if (c2 >= 0) tx[c2] = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk({tag, " R11 start clears coll"}, int'(coll_flag), 0);
    chk({tag, " R11 start clears parity"}, int'(par_err), 0);
    rx_n = 0; n_sof = 0; n_eof = 0; n_bd = 0;
    send(c1, c2, pre);
    chk({tag, " R1 sof count"}, n_sof, 1);
    chk({tag, " R7 eof count"}, n_eof, 1);
    chk({tag, " R5 R6 bit count"}, rx_n, tx_n);
    for (int i = 0; i < tx_n && i < rx_n; i++) if (rx[i] != tx[i]) mism++;
    chk({tag, " R4 R5 R7 bit mismatches"}, mism, 0);
    chk({tag, " R8 parity error"}, int'(par_err), exp_perr());
    chk({tag, " R9 byte_done count"}, n_bd, exp_bd());
    chk({tag, " R10 coll flag"}, int'(coll_flag), (ec >= 0) ? 1 : 0);
    if (ec >= 0) chk({tag, " R10 coll idx"}, int'(coll_idx), ec);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; mode = 1'b0; role = 1'b1; rate = 2'b10; start = 1'b0; signal_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset dataout", int'(dataout), 0);
    chk("R12 reset strobes", int'({bit_strobe, sof_flag, eof_flag, byte_done}), 0);
    chk("R12 reset status", int'({coll_flag, par_err}), 0);
    chk("R12 reset idx", int'(coll_idx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    build(1, 0, 1'b0);
    rx_n = 0; n_sof = 0;
    send(-1, -1, 8'h00);
    chk("R11 idle ignores line sof", n_sof, 0);
    chk("R11 idle ignores line bits", rx_n, 0);

    rate = 2'b10; role = 1'b1; mode = 1'b0;
    build(2, 0, 1'b0); run("manch424 R2", -1, -1, 8'h00);
    build(2, 3, 1'b0); run("manch2coll", 3, 10, 8'h00);
    build(1, 0, 1'b0); run("glitch", -1, -1, 8'b10000000);
    build(1, 0, 1'b0); run("both-half pre", -1, -1, 8'hFF);
    build(2, 0, 1'b1); run("bad parity", -1, -1, 8'h00);
    build(0, 7, 1'b0); run("short manch", -1, -1, 8'h00);

    rate = 2'b01; build(2, 0, 1'b0); run("manch212 R2", -1, -1, 8'h00);
    rate = 2'b00; role = 1'b1; mode = 1'b0;
    build(1, 0, 1'b0); run("R3 initiator passive", 2, -1, 8'h00);

    rate = 2'b00; role = 1'b0; mode = 1'b0;
    build(1, 0, 1'b0); tx[8] = 1'b1; tx[7] = ~tx[7] ^ 1'b0;
    begin
      logic x = 1'b0;
      for (int k = 0; k < 8; k++) x ^= tx[k];
      if (x == 1'b1) tx[7] = ~tx[7];
    end
    run("miller end1 R2", -1, -1, 8'h00);
    build(0, 7, 1'b0); tx[6] = 1'b0; run("short miller", -1, -1, 8'h00);
    role = 1'b1; mode = 1'b1;
    build(2, 0, 1'b1); run("R3 initiator active", -1, -1, 8'h00);

    for (int t = 0; t < 30; t++) begin
      int nb, ex, c;
      rate = 2'($urandom_range(0, 3));
      role = 1'($urandom); mode = 1'($urandom);
      nb = $urandom_range(0, 3);
      ex = (nb == 0) ? 7 : $urandom_range(0, 4);
      build(nb, ex, 1'($urandom));
      c = (!is_miller() && ($urandom_range(0, 2) == 0) && tx_n > 0) ? $urandom_range(0, tx_n - 1) : -1;
      run("random", c, -1, 8'h00);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule